// File: doc/BRIEF.md
# Eight-State Max-Log Forward Metric Recursion

This block runs the forward half of a max-log soft-input soft-output decoder for the constituent code of a turbo scheme. The trellis belongs to a recursive systematic convolutional encoder with constraint length 4, feedback polynomial 13 (octal) and feed-forward polynomial 15 (octal). It therefore has eight states. For each trellis step the block takes one pair of branch metrics. It adds them to the previous state metrics along the trellis edges, keeps the larger candidate for every state, and stores the resulting eight-metric vector in an external memory for a later LLR pass.

A frame starts with a single-cycle start pulse that carries the frame length N. The block then accepts N branch-metric pairs over a valid/ready handshake and issues one memory write per accepted pair. When the frame is over it raises a one-cycle done flag. All eight add-compare-select lanes work in the same cycle on 8-bit signed metrics with saturating arithmetic. The starting state is forced through a -128 sentinel on every other state.

Top module: `fwd_recursion`

## Requirements
- R1: While reset is high and in the first cycle after it, wr_en, done and bm_ready are all 0.
- R2: A start accepted while idle loads the working vector: state 0 gets 0 and states 1 to 7 get -128. The first step of the frame uses this vector.
- R3: States are numbered with bit 2 as the newest register bit s2, bit 1 as s1 and bit 0 as the oldest bit s0. For input bit u, the feedback bit is a = u^s1^s0, the parity bit is p = a^s2^s0 and the next state is {a,s2,s1}. Each new metric is the larger of its two incoming candidates, where a candidate is the old metric plus the branch metric of that edge.
- R4: The branch metric of an edge with (u,p) is chosen as follows: (1,1) uses bm_u1p1 and (1,0) uses bm_u1p0. (0,0) uses the saturated negation of bm_u1p1 and (0,1) uses the saturated negation of bm_u1p0. Negating -128 gives 127.
- R5: Every addition and negation clamps to the range -128..127 and never wraps.
- R6: Each accepted pair produces exactly one write, one cycle after acceptance. Its address is the count of pairs accepted so far in the frame (1..N). Its data holds state s in bits [8s+7:8s].
- R7: bm_ready is high only while a frame is running. A pair is consumed only at an edge where bm_valid and bm_ready are both high. While bm_valid is low, no write occurs.
- R8: After the N-th pair, bm_ready drops. done is high for exactly one cycle, in the cycle after the final write.
- R9: A start pulse seen while a frame is running or finishing is ignored, together with its frame_len.
- R10: A frame length of 0 produces no write. done pulses once, in the second cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a frame when idle |
| frame_len | input | ADDR_W | Number of trellis steps N, sampled with start |
| bm_valid | input | 1 | Branch-metric pair present |
| bm_ready | output | 1 | Block accepts a pair |
| bm_u1p1 | input | 8 | Signed branch metric of edges with u=1, p=1 |
| bm_u1p0 | input | 8 | Signed branch metric of edges with u=1, p=0 |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Trellis step index of the write |
| wr_data | output | 64 | Eight packed signed state metrics |
| done | output | 1 | One-cycle end-of-frame flag |

## Verification
The assertions assume that start arrives as a pulse and that bm_valid may be raised at any time. They also assume that the branch-metric pair stays stable for as long as bm_valid is high and bm_ready is low. The stimulus raises start for one cycle per frame and sets each pair before it raises valid. It holds the pair until the handshake edge and inserts idle gaps only by dropping valid. A start raised in the middle of a frame is deliberate and tests that the block ignores it. The stimulus also drives metrics near both saturation limits, so the ±127/-128 clamps and the sentinel are reached in real frames.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int METRIC_W   = 8;
    localparam int NUM_STATES = 8;
    localparam int STATE_BITS = $clog2(NUM_STATES);
    localparam int VEC_W      = NUM_STATES * METRIC_W;

    typedef logic signed [METRIC_W-1:0] metric_t;
    typedef logic [NUM_STATES-1:0][METRIC_W-1:0] mvec_t;
    typedef logic [STATE_BITS-1:0] state_idx_t;

    typedef struct packed {
        metric_t u1p1;
        metric_t u1p0;
    } bm_pair_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_FIN
    } phase_e;

    localparam int MAX_I = (1 << (METRIC_W - 1)) - 1;
    localparam int MIN_I = -(1 << (METRIC_W - 1));
    localparam metric_t M_MAX = metric_t'(MAX_I);
    localparam metric_t M_MIN = metric_t'(MIN_I);

    function automatic metric_t sat_add(metric_t a, metric_t b);
        int s;
        s = int'(a) + int'(b);
        if (s > MAX_I)
            return M_MAX;
        else if (s < MIN_I)
            return M_MIN;
        else
            return metric_t'(s);
    endfunction

    function automatic metric_t sat_neg(metric_t a);
        if (a == M_MIN)
            return M_MAX;
        else
            return metric_t'(-int'(a));
    endfunction

    function automatic mvec_t start_vec();
        mvec_t v;
        for (int i = 0; i < NUM_STATES; i++)
            v[i] = (i == 0) ? '0 : M_MIN;
        return v;
    endfunction

    // predecessor of state n on branch x: {n[1], n[0], x}
    function automatic state_idx_t pred_state(state_idx_t n, logic x);
        return {n[1], n[0], x};
    endfunction

    // input bit on that branch: a = n[2] = u ^ n[0] ^ x
    function automatic logic pred_input(state_idx_t n, logic x);
        return n[2] ^ n[0] ^ x;
    endfunction

    // parity bit on that branch: a ^ s2 ^ s0 = n[2] ^ n[1] ^ x
    function automatic logic pred_parity(state_idx_t n, logic x);
        return n[2] ^ n[1] ^ x;
    endfunction

    function automatic metric_t edge_metric(logic u, logic p, bm_pair_t bm);
        case ({u, p})
            2'b11:   return bm.u1p1;
            2'b10:   return bm.u1p0;
            2'b01:   return sat_neg(bm.u1p0);
            default: return sat_neg(bm.u1p1);
        endcase
    endfunction

endpackage

// File: rtl/fwd_acs_lane.sv
module fwd_acs_lane
    import fwd_pkg::*;
#(
    parameter int STATE = 0
) (
    input  mvec_t    prev,
    input  bm_pair_t bm,
    output metric_t  next
);
    localparam state_idx_t N_IDX = state_idx_t'(STATE);

    metric_t cand [2];

    always_comb begin
        for (int x = 0; x < 2; x++) begin
            cand[x] = sat_add(metric_t'(prev[pred_state(N_IDX, 1'(x))]),
                              edge_metric(pred_input(N_IDX, 1'(x)),
                                          pred_parity(N_IDX, 1'(x)), bm));
        end
        next = (cand[1] > cand[0]) ? cand[1] : cand[0];
    end

endmodule

// File: rtl/fwd_step_ctrl.sv
module fwd_step_ctrl
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] frame_len,
    input  logic              bm_valid,
    output logic              bm_ready,
    output logic              fire,
    output logic              load,
    output logic [ADDR_W-1:0] step_next,
    output logic              done
);
    phase_e            ph;
    logic [ADDR_W-1:0] len_q;
    logic [ADDR_W-1:0] step_q;
    logic              done_q;

    assign bm_ready  = (ph == PH_RUN);
    assign fire      = bm_ready && bm_valid;
    assign load      = (ph == PH_IDLE) && start;
    assign step_next = step_q + ADDR_W'(1);
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            len_q  <= '0;
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        len_q  <= frame_len;
                        step_q <= '0;
                        ph     <= (frame_len == '0) ? PH_FIN : PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (fire) begin
                        step_q <= step_next;
                        if (step_next == len_q)
                            ph <= PH_FIN;
                    end
                end
                default: begin
                    done_q <= 1'b1;
                    ph     <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fwd_recursion.sv
module fwd_recursion
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   frame_len,
    input  logic                bm_valid,
    output logic                bm_ready,
    input  logic [METRIC_W-1:0] bm_u1p1,
    input  logic [METRIC_W-1:0] bm_u1p0,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [VEC_W-1:0]    wr_data,
    output logic                done
);
    logic              fire;
    logic              load;
    logic [ADDR_W-1:0] step_next;
    mvec_t             alpha_q;
    mvec_t             alpha_d;
    bm_pair_t          bm;

    assign bm.u1p1 = metric_t'(bm_u1p1);
    assign bm.u1p0 = metric_t'(bm_u1p0);

    fwd_step_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .frame_len (frame_len),
        .bm_valid  (bm_valid),
        .bm_ready  (bm_ready),
        .fire      (fire),
        .load      (load),
        .step_next (step_next),
        .done      (done)
    );

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_lane
        metric_t lane_out;
        fwd_acs_lane #(.STATE(s)) u_lane (
            .prev (alpha_q),
            .bm   (bm),
            .next (lane_out)
        );
        assign alpha_d[s] = lane_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q <= start_vec();
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= fire;
            if (load)
                alpha_q <= start_vec();
            else if (fire)
                alpha_q <= alpha_d;
            if (fire) begin
                wr_addr <= step_next;
                wr_data <= alpha_d;
            end
        end
    end

endmodule

// File: rtl/fwd_recursion_chk.sv
module fwd_recursion_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              bm_valid,
    input logic              bm_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done
);
    p_write_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(bm_valid && bm_ready));

    p_no_write_unready_r7: assert property (@(posedge clk) disable iff (rst)
        !bm_ready |=> !wr_en);

    p_addr_from_one_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr != '0));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !bm_ready);

    p_done_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

endmodule

bind fwd_recursion fwd_recursion_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bm_valid (bm_valid),
    .bm_ready (bm_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .done     (done)
);

// File: tb/test_fwd_recursion.sv
module test_fwd_recursion;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] frame_len = '0;
    logic              bm_valid = 1'b0;
    logic              bm_ready;
    logic [7:0]        bm_u1p1 = '0;
    logic [7:0]        bm_u1p0 = '0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [63:0]       wr_data;
    logic              done;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    logic [ADDR_W+63:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_recursion #(.ADDR_W(ADDR_W)) i_fwd_recursion (
        .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
        .bm_valid(bm_valid), .bm_ready(bm_ready),
        .bm_u1p1(bm_u1p1), .bm_u1p0(bm_u1p0),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clamp(int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]);
    endfunction

    // monitor: pops the scoreboard on every write (R6, R3, R4, R5)
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected write", {wr_addr, wr_data}, 0);
            end else begin
                logic [ADDR_W+63:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R3/R4/R5/R6 write", {wr_addr, wr_data}, e);
            end
        end
    end

    task automatic run_frame(int n, int mode, bit gaps, bit poke);
        int alpha [8];
        for (int s = 0; s < 8; s++) alpha[s] = (s == 0) ? 0 : -128;   // R2
        @(negedge clk);
        start = 1'b1; frame_len = ADDR_W'(n);
        @(negedge clk);
        start = 1'b0;
        check(bm_ready == 1'b1, "R7 ready while running", bm_ready, 1);
        for (int i = 0; i < n; i++) begin
            int g11, g10;
            int nxt [8];
            logic [63:0] d;
            case (mode)
                1: begin g11 = 100 + rnd() % 28; g10 = 100 + rnd() % 28; end
                2: begin g11 = -128 + rnd() % 28; g10 = -128 + rnd() % 28; end
                3: begin g11 = rnd() % 7 - 3; g10 = rnd() % 7 - 3; end
                default: begin g11 = rnd() - 128; g10 = rnd() - 128; end
            endcase
            for (int s = 0; s < 8; s++) nxt[s] = -1000;
            for (int s = 0; s < 8; s++) begin
                for (int u = 0; u < 2; u++) begin
                    int a, p, ns, bmv, c;
                    a  = u ^ ((s >> 1) & 1) ^ (s & 1);
                    p  = a ^ ((s >> 2) & 1) ^ (s & 1);
                    ns = (a << 2) | (s >> 1);
                    if (u == 1) bmv = (p == 1) ? g11 : g10;
                    else        bmv = (p == 1) ? clamp(-g10) : clamp(-g11);
                    c = clamp(alpha[s] + bmv);
                    if (c > nxt[ns]) nxt[ns] = c;
                end
            end
            for (int s = 0; s < 8; s++) begin
                alpha[s] = nxt[s];
                d[8*s +: 8] = 8'(nxt[s]);
            end
            exp_q.push_back({ADDR_W'(i + 1), d});
            if (gaps && (rnd() & 1)) begin
                bm_valid = 1'b0;
                @(negedge clk);
            end
            bm_u1p1 = 8'(g11); bm_u1p0 = 8'(g10); bm_valid = 1'b1;
            if (poke && i == 2) begin
                start = 1'b1; frame_len = ADDR_W'(3);   // R9: must be ignored
            end
            while (!bm_ready) @(negedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        bm_valid = 1'b0;
        check(bm_ready == 1'b0, "R8 ready drops after last pair", bm_ready, 0);
        check(done == 1'b0, "R8 done not with final write", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R8 done after final write", done, 1);
        check(bm_ready == 1'b0, "R8 ready low at done", bm_ready, 0);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", done, 0);
        check(exp_q.size() == 0, "R6 write count", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(wr_en == 0 && done == 0 && bm_ready == 0, "R1 reset outputs",
              {wr_en, done, bm_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(wr_en == 0 && done == 0 && bm_ready == 0, "R1 after reset",
              {wr_en, done, bm_ready}, 0);
        check(bm_ready == 0, "R7 not ready while idle", bm_ready, 0);

        run_frame(5, 0, 1'b0, 1'b0);    // R2 R3 mixed metrics
        run_frame(1, 0, 1'b0, 1'b0);    // R8 shortest frame
        run_frame(20, 1, 1'b0, 1'b0);   // R5 upper clamp, R4 negation
        run_frame(20, 2, 1'b1, 1'b0);   // R4 -128 negation, R5 lower clamp, R7 gaps
        run_frame(40, 3, 1'b1, 1'b0);   // R3 small metrics, R7 gaps
        run_frame(9, 0, 1'b0, 1'b1);    // R9 start ignored while running

        // R10 zero-length frame
        @(negedge clk);
        start = 1'b1; frame_len = '0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && bm_ready == 1'b0, "R10 no run on zero length",
              {done, bm_ready}, 0);
        @(negedge clk);
        check(done == 1'b1, "R10 done for zero length", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", done, 0);
        check(exp_q.size() == 0, "R10 no writes", exp_q.size(), 0);

        run_frame(6, 0, 1'b1, 1'b0);    // R2 vector reloaded for a new frame

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule